// File: doc/BRIEF.md
# Serial DAC Command and Power Controller

This block is the digital front end of a single-channel voltage DAC. A host writes 16-bit command frames over a three-wire serial link made of an active-low select, a serial clock and a data line. The block decodes a 4-bit opcode in each frame. It moves data through a staged pair of registers: a holding register that the frame can fill, and an output register whose value is the code the converter sees. It also runs a three-state power controller and stores a 2-bit reference-select field.

The three serial inputs pass through two-flop synchronizers into the system clock domain. Edges are detected there, so the system clock must run at least four times faster than the serial clock. A frame takes effect only when the select line returns high after exactly sixteen serial clock rises. The outputs drive the analog side directly: the converter code, an enable for the output buffer, an enable for the reference, and the reference-select bits. The parameter `HAS_REF` builds the variant without an internal reference. In that variant a standby command powers the device fully down.

Top module: `serdac_ctrl`

## Requirements
- R1: After reset, `dac_code` is 0, the holding register is 0, the power state is active (`out_en`=1, `ref_en`=1) and `ref_sel` is 00.
- R2: Frame bits are captured on serial clock rises while `spi_cs_n` is low, most significant bit first, as opcode[15:12], data[11:4] and sub-bits[3:0]. A frame acts only after `spi_cs_n` rises, and every output is otherwise held.
- R3: Opcode 0001 writes the data into the holding register. `dac_code` and the power state are left unchanged.
- R4: Opcode 1000 copies the holding register into `dac_code` and sets the power state to active from any state.
- R5: Opcodes 1001 and 1111 write the data into both the holding register and `dac_code`, and set the power state to active.
- R6: Opcode 1100 received while active or in standby puts the block in standby: `out_en`=0, `ref_en`=1, and `dac_code` is kept.
- R7: Opcode 1110 puts the block in full power-down: `out_en`=0, `ref_en`=0.
- R8: Opcode 1101 sets the power state to active and leaves `dac_code` as it was.
- R9: Opcode 1100 received during full power-down is ignored. The power state and `ref_sel` do not change.
- R10: On opcodes 1100 (when accepted), 1101 and 1110, `ref_sel` takes the top two data bits, D7..D6, which are frame bits [11:10].
- R11: Opcode 0000 and the reserved opcodes 0010 to 0111, 1010 and 1011 change nothing.
- R12: A frame closed after any number of serial clock rises other than 16 is dropped with no state change.
- R13: A frame whose sub-bits are not all zero is treated as opcode 0000.
- R14: With `HAS_REF`=0, an accepted opcode 1100 enters full power-down (`ref_en`=0) instead of standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Serial frame select, active low |
| spi_sclk | input | 1 | Serial clock; data sampled on its rise |
| spi_mosi | input | 1 | Serial data in |
| dac_code | output | 8 | Code driven to the converter |
| out_en | output | 1 | Analog output buffer enable |
| ref_en | output | 1 | Reference enable |
| ref_sel | output | 2 | Reference voltage select |

## Verification
The bench builds two copies of the block on the same serial inputs, one with `HAS_REF`=1 and one with `HAS_REF`=0. This lets a single command stream compare the standby path against the variant that turns standby into full power-down. Sixteen system clocks per serial bit keep the synchronizer ratio safe. The bench can send frames of 15 and 17 bits, which exercise both sides of the length check. The holding register is observed only through later copy commands, so every dropped or reserved frame is checked by what a following transfer puts on `dac_code`.

// File: rtl/serdac_pkg.sv
package serdac_pkg;

    typedef enum logic [1:0] {
        PWR_ON   = 2'd0,
        PWR_STBY = 2'd1,
        PWR_OFF  = 2'd2
    } pwr_e;

    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_NOP       = 4'b0000;
    localparam logic [OPC_W-1:0] OPC_HOLD_LD   = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_XFER      = 4'b1000;
    localparam logic [OPC_W-1:0] OPC_BOTH_LD   = 4'b1001;
    localparam logic [OPC_W-1:0] OPC_STBY      = 4'b1100;
    localparam logic [OPC_W-1:0] OPC_WAKE      = 4'b1101;
    localparam logic [OPC_W-1:0] OPC_OFF       = 4'b1110;
    localparam logic [OPC_W-1:0] OPC_BOTH_LD2  = 4'b1111;

endpackage

// File: rtl/serdac_sync.sv
module serdac_sync #(
    parameter int               W       = 3,
    parameter int               STAGES  = 2,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] st_d [STAGES];
    logic [W-1:0] st_q [STAGES];

    always_comb begin
        st_d[0] = async_i;
        for (int k = 1; k < STAGES; k++) begin
            st_d[k] = st_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) begin
                st_q[k] <= RST_VAL;
            end
        end else begin
            for (int k = 0; k < STAGES; k++) begin
                st_q[k] <= st_d[k];
            end
        end
    end

    assign sync_o = st_q[STAGES-1];

endmodule

// File: rtl/serdac_rx.sv
module serdac_rx #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n_s,
    input  logic               sclk_s,
    input  logic               din_s,
    output logic               frame_vld,
    output logic [FRAME_W-1:0] frame_data
);

    localparam int CNT_MAX = FRAME_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic               sclk_prev;
        logic               cs_prev;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] shreg;
        logic               vld;
        logic [FRAME_W-1:0] frame;
    } rx_t;

    rx_t rx_d, rx_q;

    logic             sclk_rise;
    logic             cs_fall;
    logic             cs_rise;
    logic [CNT_W-1:0] cnt_base;

    always_comb begin
        rx_d           = rx_q;
        rx_d.vld       = 1'b0;
        rx_d.sclk_prev = sclk_s;
        rx_d.cs_prev   = cs_n_s;

        sclk_rise = sclk_s && !rx_q.sclk_prev;
        cs_fall   = !cs_n_s && rx_q.cs_prev;
        cs_rise   = cs_n_s && !rx_q.cs_prev;

        cnt_base  = cs_fall ? '0 : rx_q.cnt;
        rx_d.cnt  = cnt_base;

        if (sclk_rise && !cs_n_s) begin
            rx_d.shreg = {rx_q.shreg[FRAME_W-2:0], din_s};
            if (cnt_base == CNT_W'(CNT_MAX)) begin
                rx_d.cnt = cnt_base;
            end else begin
                rx_d.cnt = cnt_base + 1'b1;
            end
        end

        if (cs_rise && (rx_q.cnt == CNT_W'(FRAME_W))) begin
            rx_d.vld   = 1'b1;
            rx_d.frame = rx_q.shreg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q           <= '0;
            rx_q.cs_prev   <= 1'b1;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign frame_vld  = rx_q.vld;
    assign frame_data = rx_q.frame;

    // R12: a frame is released only when exactly FRAME_W bits were counted
    assert_len_exact_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q.vld |-> ($past(rx_q.cnt) == CNT_W'(FRAME_W)));

    // R12: the bit counter saturates one past the frame length
    assert_cnt_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q.cnt <= CNT_W'(CNT_MAX));

    // R2: one command pulse per select rise
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q.vld |=> !rx_q.vld);

endmodule

// File: rtl/serdac_core.sv
module serdac_core
    import serdac_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int SUB_W   = 4,
    parameter int REF_W   = 2,
    parameter bit HAS_REF = 1'b1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              frame_vld,
    input  logic [OPC_W+DATA_W+SUB_W-1:0]     frame_data,
    output logic [DATA_W-1:0]                 dac_code,
    output logic                              out_en,
    output logic                              ref_en,
    output logic [REF_W-1:0]                  ref_sel
);

    localparam int FRAME_W = OPC_W + DATA_W + SUB_W;

    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic [DATA_W-1:0] dac;
        pwr_e              mode;
        logic [REF_W-1:0]  rsel;
    } core_t;

    core_t core_d, core_q;

    logic [OPC_W-1:0]  opc;
    logic [DATA_W-1:0] dat;
    logic [SUB_W-1:0]  sub;
    logic [REF_W-1:0]  rbits;
    logic              sub_ok;

    assign opc    = frame_data[FRAME_W-1 -: OPC_W];
    assign dat    = frame_data[SUB_W +: DATA_W];
    assign sub    = frame_data[SUB_W-1:0];
    assign rbits  = dat[DATA_W-1 -: REF_W];
    assign sub_ok = (sub == '0);

    always_comb begin
        core_d = core_q;
        if (frame_vld && sub_ok) begin
            unique case (opc)
                OPC_HOLD_LD: begin
                    core_d.hold = dat;
                end
                OPC_XFER: begin
                    core_d.dac  = core_q.hold;
                    core_d.mode = PWR_ON;
                end
                OPC_BOTH_LD, OPC_BOTH_LD2: begin
                    core_d.hold = dat;
                    core_d.dac  = dat;
                    core_d.mode = PWR_ON;
                end
                OPC_STBY: begin
                    if (core_q.mode != PWR_OFF) begin
                        core_d.mode = HAS_REF ? PWR_STBY : PWR_OFF;
                        core_d.rsel = rbits;
                    end
                end
                OPC_WAKE: begin
                    core_d.mode = PWR_ON;
                    core_d.rsel = rbits;
                end
                OPC_OFF: begin
                    core_d.mode = PWR_OFF;
                    core_d.rsel = rbits;
                end
                default: begin
                    core_d = core_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q      <= '0;
            core_q.mode <= PWR_ON;
        end else begin
            core_q <= core_d;
        end
    end

    assign dac_code = core_q.dac;
    assign out_en   = (core_q.mode == PWR_ON);
    assign ref_en   = (core_q.mode != PWR_OFF);
    assign ref_sel  = core_q.rsel;

    logic is_reserved;
    assign is_reserved = (opc inside {4'b0010, 4'b0011, 4'b0100, 4'b0101,
                                      4'b0110, 4'b0111, 4'b1010, 4'b1011});

    // R2: without a command pulse every piece of state holds
    assert_quiet_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld |=> $stable({core_q.hold, core_q.dac, core_q.mode, core_q.rsel}));

    // R9: full power-down never leads straight into standby
    assert_no_off_to_stby_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.mode == PWR_OFF) |=> (core_q.mode != PWR_STBY));

    // R3: a holding-register load leaves the converter code alone
    assert_hold_keeps_dac_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && sub_ok && opc == OPC_HOLD_LD) |=> $stable(core_q.dac));

    // R11: reserved opcodes leave everything as it was
    assert_reserved_nop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && is_reserved) |=> $stable({core_q.hold, core_q.dac, core_q.mode, core_q.rsel}));

    // R13: non-zero sub-bits turn the frame into a no-op
    assert_subbits_nop_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && !sub_ok) |=> $stable({core_q.hold, core_q.dac, core_q.mode, core_q.rsel}));

    generate
        if (!HAS_REF) begin : g_noref_chk
            // R14: without an internal reference standby is never reached
            assert_no_stby_R14: assert property (@(posedge clk) disable iff (!rst_n)
                core_q.mode != PWR_STBY);
        end
    endgenerate

endmodule

// File: rtl/serdac_ctrl.sv
module serdac_ctrl #(
    parameter int DATA_W      = 8,
    parameter int SUB_W       = 4,
    parameter int REF_W       = 2,
    parameter int SYNC_STAGES = 2,
    parameter bit HAS_REF     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    output logic [DATA_W-1:0] dac_code,
    output logic              out_en,
    output logic              ref_en,
    output logic [REF_W-1:0]  ref_sel
);

    localparam int FRAME_W = serdac_pkg::OPC_W + DATA_W + SUB_W;

    logic [2:0]         pins_s;
    logic               frame_vld;
    logic [FRAME_W-1:0] frame_data;

    serdac_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({spi_cs_n, spi_sclk, spi_mosi}),
        .sync_o  (pins_s)
    );

    serdac_rx #(
        .FRAME_W (FRAME_W)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_s     (pins_s[2]),
        .sclk_s     (pins_s[1]),
        .din_s      (pins_s[0]),
        .frame_vld  (frame_vld),
        .frame_data (frame_data)
    );

    serdac_core #(
        .DATA_W  (DATA_W),
        .SUB_W   (SUB_W),
        .REF_W   (REF_W),
        .HAS_REF (HAS_REF)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_vld  (frame_vld),
        .frame_data (frame_data),
        .dac_code   (dac_code),
        .out_en     (out_en),
        .ref_en     (ref_en),
        .ref_sel    (ref_sel)
    );

endmodule

// File: tb/sim_serdac_ctrl.sv
module sim_serdac_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic mosi = 1'b0;

    logic [7:0] code [2];
    logic       oen  [2];
    logic       ren  [2];
    logic [1:0] rsel [2];

    always #2.5 clk = ~clk;

    serdac_ctrl #(.HAS_REF(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
        .dac_code(code[0]), .out_en(oen[0]), .ref_en(ren[0]), .ref_sel(rsel[0])
    );

    serdac_ctrl #(.HAS_REF(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
        .dac_code(code[1]), .out_en(oen[1]), .ref_en(ren[1]), .ref_sel(rsel[1])
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model: mode 0 active, 1 standby, 2 power-down
    logic [7:0] m_hold [2];
    logic [7:0] m_dac  [2];
    int         m_mode [2];
    logic [1:0] m_ref  [2];

    task automatic model_reset();
        for (int v = 0; v < 2; v++) begin
            m_hold[v] = 8'h00; m_dac[v] = 8'h00; m_mode[v] = 0; m_ref[v] = 2'b00;
        end
    endtask

    task automatic model_apply(input logic [3:0] op, input logic [7:0] dat,
                               input logic [3:0] sub, input int nbits);
        if (nbits != 16 || sub != 4'h0) return;
        for (int v = 0; v < 2; v++) begin
            case (op)
                4'b0001: m_hold[v] = dat;
                4'b1000: begin m_dac[v] = m_hold[v]; m_mode[v] = 0; end
                4'b1001, 4'b1111: begin m_hold[v] = dat; m_dac[v] = dat; m_mode[v] = 0; end
                4'b1100: if (m_mode[v] != 2) begin
                    m_mode[v] = (v == 0) ? 1 : 2;
                    m_ref[v]  = dat[7:6];
                end
                4'b1101: begin m_mode[v] = 0; m_ref[v] = dat[7:6]; end
                4'b1110: begin m_mode[v] = 2; m_ref[v] = dat[7:6]; end
                default: ;
            endcase
        end
    endtask

    task automatic check_out(input string req);
        for (int v = 0; v < 2; v++) begin
            logic [11:0] act, exp;
            act = {code[v], oen[v], ren[v], rsel[v]};
            exp = {m_dac[v], (m_mode[v] == 0), (m_mode[v] != 2), m_ref[v]};
            checks++;
            if (act !== exp) begin
                fails++;
                $display("FAIL %s variant %0d: code/oen/ren/rsel actual %h/%b/%b/%b expected %h/%b/%b/%b",
                         req, v, act[11:4], act[3], act[2], act[1:0],
                         exp[11:4], exp[3], exp[2], exp[1:0]);
            end
        end
    endtask

    task automatic send(input logic [3:0] op, input logic [7:0] dat,
                        input logic [3:0] sub, input int nbits);
        logic [15:0] fr;
        fr = {op, dat, sub};
        @(negedge clk);
        cs_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 16) ? fr[15-i] : 1'b0;
            repeat (8) @(negedge clk);
            sclk = 1'b1;
            repeat (8) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (8) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
        model_apply(op, dat, sub, nbits);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_out("R1");

        send(4'b0001, 8'hA5, 4'h0, 16); check_out("R3");
        send(4'b1000, 8'h00, 4'h0, 16); check_out("R4 R2");
        send(4'b1001, 8'h3C, 4'h0, 16); check_out("R5 R2");
        send(4'b1111, 8'hC3, 4'h0, 16); check_out("R5");
        send(4'b1100, 8'h80, 4'h0, 16); check_out("R6 R10 R14");
        send(4'b1101, 8'h40, 4'h0, 16); check_out("R8 R10");
        send(4'b1100, 8'hC0, 4'h0, 16); check_out("R6 R14");
        send(4'b1100, 8'h00, 4'h0, 16); check_out("R6 R10");
        send(4'b1110, 8'hC0, 4'h0, 16); check_out("R7 R10");
        send(4'b1100, 8'h40, 4'h0, 16); check_out("R9");
        send(4'b1000, 8'h00, 4'h0, 16); check_out("R4");
        send(4'b0001, 8'h11, 4'h5, 16); send(4'b1000, 8'h00, 4'h0, 16); check_out("R13");
        send(4'b1001, 8'h77, 4'h8, 16); check_out("R13");
        send(4'b0001, 8'h22, 4'h0, 15); send(4'b1000, 8'h00, 4'h0, 16); check_out("R12");
        send(4'b1001, 8'h33, 4'h0, 17); check_out("R12");
        send(4'b1110, 8'h00, 4'h0, 12); check_out("R12");
        send(4'b0110, 8'h5A, 4'h0, 16); send(4'b1000, 8'h00, 4'h0, 16); check_out("R11");
        send(4'b1011, 8'hFF, 4'h0, 16); check_out("R11");
        send(4'b0000, 8'hEE, 4'h0, 16); check_out("R11");

        for (int n = 0; n < 120; n++) begin
            logic [3:0] op;
            logic [7:0] dat;
            logic [3:0] sub;
            int nb;
            op  = 4'($urandom % 16);
            dat = 8'($urandom);
            sub = (($urandom % 8) == 0) ? 4'($urandom % 15 + 1) : 4'h0;
            nb  = (($urandom % 10) == 0) ? ((($urandom % 2) == 0) ? 15 : 17) : 16;
            send(op, dat, sub, nb);
            check_out("R2 random");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule